// File: doc/BRIEF.md
# Converter Control Port with Serial Mode Entry

This block is the digital control front end of a data converter. After reset it runs in a static strap mode. In that mode the serial pins are plain level inputs: the data pin sets the output standard and the clock pin sets the number format, both live. The first falling edge of the active-low select samples both pins, stores them as start-up defaults and moves the block into serial register mode. The block never leaves serial register mode.

In serial register mode a host writes or reads a small register file over a 3-wire port: select, clock and one bidirectional data line. The data line is modelled as a separate input, output and output-enable. The register file drives these controls: operating mode, clock divide-by-two, duty-cycle stabiliser, a self-clearing digital reset, output standard, output bit-order swap and data format. The serial pins are synchronised into the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `conv_ctl_port`

## Requirements
- R1: After reset the block is in strap mode (serialMode 0), opMode is 00, clkDivEn is 0, dcsEn is 1, busSwap is 0 and sdioOe is 0. In strap mode lvdsSel follows the data pin level and dataFmt equals {0, clock pin level}.
- R2: The first falling edge of csN sets serialMode to 1 for good. At that edge the block stores lvdsSel = data pin level, and dataFmt = 00 when the clock pin is low or 01 when it is high. From then on the pin levels outside frames have no effect on these outputs.
- R3: A frame is 24 bits, MSB first, each sampled on a rising serial clock edge while csN is low. The bits are: one direction bit (1 = read, 0 = write), then a 15-bit register address, then 8 data bits. A write takes effect on the 24th rising edge.
- R4: Register 0x0005 has two fields. Bit 7 is the soft-reset request. Bits 1:0 are opMode: 00 normal, 01 power-down, 10 sleep.
- R5: Register 0x0006 has two fields. Bit 3 is clkDivEn. Bit 0 is dcsEn.
- R6: Register 0x0011 has three fields. Bit 3 is lvdsSel. Bit 2 is busSwap. Bits 1:0 are dataFmt.
- R7: During a read, sdioOe rises on the first falling serial clock edge after the 16th rising edge, and stays high until csN goes high. sdioOut presents the 8 data bits MSB first, advancing on each later falling edge. Unmapped addresses read as 0x00.
- R8: If csN rises before the 24th rising edge, the frame writes nothing.
- R9: Writing 1 to bit 7 of 0x0005 makes digReset high for exactly one system cycle. Every register then returns to its default, with 0x0011 going back to the values stored at mode entry. The block stays in serial mode, and bit 7 reads back as 0.
- R10: sdioOe is never high in strap mode or during a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; strap input for number format |
| sdioIn | input | 1 | Data line input; strap input for output standard |
| sdioOut | output | 1 | Data line output value during reads |
| sdioOe | output | 1 | Data line output enable |
| serialMode | output | 1 | 1 once serial register mode is entered |
| opMode | output | 2 | Operating mode (00 normal, 01 power-down, 10 sleep) |
| clkDivEn | output | 1 | Input clock divide-by-two enable |
| dcsEn | output | 1 | Duty-cycle stabiliser enable |
| digReset | output | 1 | One-cycle reset pulse for the digital section |
| lvdsSel | output | 1 | 1 = differential DDR output, 0 = CMOS |
| busSwap | output | 1 | Output bus bit-order swap |
| dataFmt | output | 2 | Output number format (00 offset binary, 01 two's complement) |

## Verification
The bench builds the block with its default parameters: a 15-bit address, 8-bit data and a two-stage synchroniser. With these values the full 24-bit frame is exercised, including the bit where the direction is decided, the write commit on the last bit and an aborted frame 4 bits short. The two-stage synchroniser fixes a latency of a few system cycles, which the bench allows for. A reference model then checks the strap-to-serial handover, readback of all three registers and of an unmapped address, and the soft reset restoring the strapped format.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  // Strobes from frame control to the register datapath
  typedef struct packed {
    logic latchStrap;  // first select fall: capture strap levels
    logic shiftIn;     // one serial bit sampled
    logic hdrDone;     // last instruction bit sampled
    logic loadRead;    // load readback shifter
    logic commitWr;    // last data bit of a write sampled
    logic shiftOut;    // advance readback shifter
    logic serBit;      // synchronised data pin level
    logic sclkLvl;     // synchronised clock pin level
  } ccp_strobe_t;
endpackage

// File: rtl/ccp_ctrl.sv
module ccp_ctrl #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdioIn,
  output ccp_pkg::ccp_strobe_t strb,
  output logic                serialMode,
  output logic                sdioOe
);
  localparam int INSTR_W = ADDR_W + 1;
  localparam int FRAME_W = INSTR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(INSTR_W);

  logic [SYNC_STAGES-1:0] csSh, ckSh, dSh;
  logic csS, ckS, dS, csPrev, ckPrev;
  logic csFall, sclkRise, sclkFall, inFrame;
  logic [CNT_W-1:0] bitCnt;
  logic rdFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSh   <= '1;
      ckSh   <= '0;
      dSh    <= '0;
      csPrev <= 1'b1;
      ckPrev <= 1'b0;
    end else begin
      csSh   <= {csSh[SYNC_STAGES-2:0], csN};
      ckSh   <= {ckSh[SYNC_STAGES-2:0], sclk};
      dSh    <= {dSh[SYNC_STAGES-2:0], sdioIn};
      csPrev <= csS;
      ckPrev <= ckS;
    end
  end

  assign csS = csSh[SYNC_STAGES-1];
  assign ckS = ckSh[SYNC_STAGES-1];
  assign dS  = dSh[SYNC_STAGES-1];

  always_comb begin
    csFall   = csPrev & ~csS;
    sclkRise = ckS & ~ckPrev;
    sclkFall = ~ckS & ckPrev;
    inFrame  = serialMode & ~csS;
    strb.latchStrap = csFall & ~serialMode;
    strb.shiftIn    = inFrame & sclkRise & (bitCnt < CNT_FULL);
    strb.hdrDone    = strb.shiftIn & (bitCnt == CNT_HDR);
    strb.loadRead   = strb.hdrDone & rdFlag;
    strb.commitWr   = strb.shiftIn & (bitCnt == CNT_LAST) & ~rdFlag;
    strb.shiftOut   = inFrame & sclkFall & rdFlag & sdioOe;
    strb.serBit     = dS;
    strb.sclkLvl    = ckS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serialMode <= 1'b0;
      bitCnt     <= '0;
      rdFlag     <= 1'b0;
      sdioOe     <= 1'b0;
    end else begin
      if (csFall) begin
        serialMode <= 1'b1;
        bitCnt     <= '0;
        rdFlag     <= 1'b0;
      end else if (strb.shiftIn) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == '0) rdFlag <= dS;
      end
      if (csS)
        sdioOe <= 1'b0;
      else if (inFrame & sclkFall & rdFlag & (bitCnt >= CNT_DATA))
        sdioOe <= 1'b1;
    end
  end
endmodule

// File: rtl/ccp_regs.sv
module ccp_regs #(
  parameter int              ADDR_W   = 15,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] ADDR_MODE = 15'h0005,
  parameter logic [ADDR_W-1:0] ADDR_CLK  = 15'h0006,
  parameter logic [ADDR_W-1:0] ADDR_FMT  = 15'h0011
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ccp_pkg::ccp_strobe_t strb,
  input  logic                 serialMode,
  output logic                 sdioOut,
  output logic [1:0]           opMode,
  output logic                 clkDivEn,
  output logic                 dcsEn,
  output logic                 digReset,
  output logic                 lvdsSel,
  output logic                 busSwap,
  output logic [1:0]           dataFmt
);
  localparam int B_RST  = 7;
  localparam int B_DIV  = 3;
  localparam int B_DCS  = 0;
  localparam int B_LVDS = 3;
  localparam int B_SWAP = 2;

  logic [ADDR_W-2:0] inShift;
  logic [ADDR_W-1:0] addrQ, newAddr;
  logic [DATA_W-1:0] newWord, outShift;
  logic       rstBit, divQ, dcsQ, lvdsQ, swapQ, strapLvds;
  logic [1:0] modeQ, fmtQ, strapFmt;

  assign newAddr = {inShift, strb.serBit};
  assign newWord = {inShift[DATA_W-2:0], strb.serBit};

  function automatic logic [DATA_W-1:0] readMux(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v;
    v = '0;
    if (a == ADDR_MODE) begin
      v[B_RST] = rstBit;
      v[1:0]   = modeQ;
    end else if (a == ADDR_CLK) begin
      v[B_DIV] = divQ;
      v[B_DCS] = dcsQ;
    end else if (a == ADDR_FMT) begin
      v[B_LVDS] = lvdsQ;
      v[B_SWAP] = swapQ;
      v[1:0]    = fmtQ;
    end
    return v;
  endfunction

  // Serial shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      addrQ    <= '0;
      outShift <= '0;
    end else begin
      if (strb.shiftIn)  inShift  <= newAddr[ADDR_W-2:0];
      if (strb.hdrDone)  addrQ    <= newAddr;
      if (strb.loadRead) outShift <= readMux(newAddr);
      else if (strb.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstBit <= 1'b0; modeQ <= 2'b00; divQ <= 1'b0; dcsQ <= 1'b1;
      lvdsQ <= 1'b0; swapQ <= 1'b0; fmtQ <= 2'b00;
      strapLvds <= 1'b0; strapFmt <= 2'b00;
    end else if (rstBit) begin
      rstBit <= 1'b0; modeQ <= 2'b00; divQ <= 1'b0; dcsQ <= 1'b1;
      lvdsQ <= strapLvds; swapQ <= 1'b0; fmtQ <= strapFmt;
    end else if (strb.latchStrap) begin
      strapLvds <= strb.serBit;
      strapFmt  <= {1'b0, strb.sclkLvl};
      lvdsQ     <= strb.serBit;
      fmtQ      <= {1'b0, strb.sclkLvl};
    end else if (strb.commitWr) begin
      if (addrQ == ADDR_MODE) begin
        if (newWord[B_RST]) rstBit <= 1'b1;
        else                modeQ  <= newWord[1:0];
      end else if (addrQ == ADDR_CLK) begin
        divQ <= newWord[B_DIV];
        dcsQ <= newWord[B_DCS];
      end else if (addrQ == ADDR_FMT) begin
        lvdsQ <= newWord[B_LVDS];
        swapQ <= newWord[B_SWAP];
        fmtQ  <= newWord[1:0];
      end
    end
  end

  assign sdioOut  = outShift[DATA_W-1];
  assign opMode   = modeQ;
  assign clkDivEn = divQ;
  assign dcsEn    = dcsQ;
  assign digReset = rstBit;
  assign busSwap  = swapQ;
  assign lvdsSel  = serialMode ? lvdsQ : strb.serBit;
  assign dataFmt  = serialMode ? fmtQ : {1'b0, strb.sclkLvl};
endmodule

// File: rtl/conv_ctl_port.sv
module conv_ctl_port #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdioIn,
  output logic       sdioOut,
  output logic       sdioOe,
  output logic       serialMode,
  output logic [1:0] opMode,
  output logic       clkDivEn,
  output logic       dcsEn,
  output logic       digReset,
  output logic       lvdsSel,
  output logic       busSwap,
  output logic [1:0] dataFmt
);
  ccp_pkg::ccp_strobe_t strb;

  ccp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .strb(strb), .serialMode(serialMode), .sdioOe(sdioOe)
  );

  ccp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .serialMode(serialMode),
    .sdioOut(sdioOut), .opMode(opMode), .clkDivEn(clkDivEn), .dcsEn(dcsEn),
    .digReset(digReset), .lvdsSel(lvdsSel), .busSwap(busSwap), .dataFmt(dataFmt)
  );
endmodule

// File: rtl/ccp_checker.sv
module ccp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       serialMode,
  input logic       sdioOe,
  input logic       digReset,
  input logic [1:0] opMode,
  input logic       clkDivEn,
  input logic       dcsEn,
  input logic       busSwap
);
  assert_pin_defaults_R1: assert property (@(posedge clk) disable iff (!rstN)
    !serialMode |-> (opMode == 2'b00 && !clkDivEn && dcsEn && !busSwap));

  assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(serialMode));

  assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN, 1) && $past(csN, 2) && $past(csN, 3)) |-> !sdioOe);

  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    digReset |=> !digReset);

  assert_rst_defaults_R9: assert property (@(posedge clk) disable iff (!rstN)
    digReset |=> (opMode == 2'b00 && !clkDivEn && dcsEn && !busSwap && serialMode));

  assert_oe_serial_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> serialMode);
endmodule

bind conv_ctl_port ccp_checker u_ccp_checker (.*);

// File: tb/test_conv_ctl_port.sv
module test_conv_ctl_port;
  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b1, sdioIn = 1'b1;
  logic sdioOut, sdioOe, serialMode, clkDivEn, dcsEn, digReset, lvdsSel, busSwap;
  logic [1:0] opMode, dataFmt;

  always #2.5 clk = ~clk;

  conv_ctl_port i_conv_ctl_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .serialMode(serialMode), .opMode(opMode),
    .clkDivEn(clkDivEn), .dcsEn(dcsEn), .digReset(digReset), .lvdsSel(lvdsSel),
    .busSwap(busSwap), .dataFmt(dataFmt)
  );

  int total = 0, bad = 0, cyc = 0, lastChg = 0, rstSeen = 0, rstExp = 0;
  bit done = 0;
  // reference model
  bit mSerial = 0, mOe = 0, mDiv = 0, mDcs = 1, mLvds = 0, mSwap = 0, mStrapLvds = 0;
  bit [1:0] mMode = 0, mFmt = 0, mStrapFmt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit [7:0] expRead(input bit [14:0] a);
    case (a)
      15'h0005: return {6'b0, mMode};
      15'h0006: return {4'b0, mDiv, 2'b0, mDcs};
      15'h0011: return {4'b0, mLvds, mSwap, mFmt};
      default:  return 8'h00;
    endcase
  endfunction

  task automatic applyWrite(input bit [14:0] a, input bit [7:0] d);
    case (a)
      15'h0005: if (d[7]) begin
                  rstExp++; mMode = 0; mDiv = 0; mDcs = 1; mSwap = 0;
                  mLvds = mStrapLvds; mFmt = mStrapFmt;
                end else mMode = d[1:0];
      15'h0006: begin mDiv = d[3]; mDcs = d[0]; end
      15'h0011: begin mLvds = d[3]; mSwap = d[2]; mFmt = d[1:0]; end
      default: ;
    endcase
  endtask

  // per-clock comparison once pins have been quiet long enough
  always @(negedge clk) begin
    if (digReset) rstSeen++;
    if (rstN && !done && (cyc - lastChg >= 6)) begin
      chk("R2", "serialMode", serialMode, mSerial);
      chk("R7", "sdioOe", sdioOe, mOe);
      chk("R4", "opMode", opMode, mMode);
      chk("R5", "clkDivEn", clkDivEn, mDiv);
      chk("R5", "dcsEn", dcsEn, mDcs);
      chk("R6", "busSwap", busSwap, mSwap);
      chk("R1", "lvdsSel", lvdsSel, mSerial ? mLvds : sdioIn);
      chk("R1", "dataFmt", dataFmt, mSerial ? mFmt : {1'b0, sclk});
    end
  end

  task automatic hold();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic mark();
    lastChg = cyc;
  endtask

  task automatic frame(input bit rd, input bit [14:0] a, input bit [7:0] d,
                       input int nbits, output bit [7:0] q);
    bit [23:0] fb;
    bit [7:0] ev;
    fb = {rd, a, d};
    ev = expRead(a);
    q = 0;
    csN = 0; mark();
    if (!mSerial) begin
      mSerial = 1; mStrapLvds = sdioIn; mStrapFmt = {1'b0, sclk};
      mLvds = mStrapLvds; mFmt = mStrapFmt;
    end
    hold();
    for (int i = 0; i < nbits; i++) begin
      if (rd && i >= 16) begin
        sclk = 0; mark();
        if (i == 16) mOe = 1;
        hold();
        q[23 - i] = sdioOut;
        chk("R7", "read bit", sdioOut, ev[23 - i]);
        chk("R7", "oe in data phase", sdioOe, 1);
        sclk = 1; mark(); hold();
      end else begin
        sclk = 0; sdioIn = fb[23 - i]; mark(); hold();
        sclk = 1; mark();
        if (i == 23 && !rd) applyWrite(a, d);
        hold();
      end
    end
    sclk = 0; mark(); hold();
    csN = 1; mOe = 0; mark(); hold();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [7:0] q;
    repeat (4) @(posedge clk);
    #1 rstN = 1; mark();
    hold();
    // R1: reset state, strap mode with data pin 1 and clock pin 1
    chk("R1", "reset serialMode", serialMode, 0);
    chk("R1", "reset opMode", opMode, 0);
    chk("R1", "reset dcsEn", dcsEn, 1);
    chk("R1", "strap lvdsSel", lvdsSel, 1);
    chk("R1", "strap dataFmt", dataFmt, 1);
    // R1: live strap levels
    sdioIn = 0; sclk = 0; mark(); hold();
    chk("R1", "live lvdsSel", lvdsSel, 0);
    chk("R1", "live dataFmt", dataFmt, 0);
    chk("R10", "oe in strap mode", sdioOe, 0);
    // R2: entry with data pin high, clock pin low
    sdioIn = 1; mark(); hold();
    frame(0, 15'h0006, 8'h08, 24, q);          // R5 write
    chk("R2", "entered serial", serialMode, 1);
    chk("R2", "strapped lvdsSel", lvdsSel, 1);
    chk("R2", "strapped dataFmt", dataFmt, 0);
    chk("R5", "clkDivEn set", clkDivEn, 1);
    chk("R5", "dcsEn cleared", dcsEn, 0);
    // R2: pin levels outside frames have no effect now
    sdioIn = 0; sclk = 1; mark(); hold();
    chk("R2", "pins ignored lvdsSel", lvdsSel, 1);
    chk("R2", "pins ignored dataFmt", dataFmt, 0);
    sclk = 0; mark(); hold();
    frame(1, 15'h0006, 8'h00, 24, q);
    chk("R3", "readback 0006", q, 8'h08);
    frame(0, 15'h0005, 8'h01, 24, q);
    chk("R4", "power-down", opMode, 1);
    frame(0, 15'h0005, 8'h02, 24, q);
    chk("R4", "sleep", opMode, 2);
    frame(0, 15'h0011, 8'h07, 24, q);
    chk("R6", "lvdsSel cleared", lvdsSel, 0);
    chk("R6", "busSwap set", busSwap, 1);
    chk("R6", "dataFmt written", dataFmt, 3);
    chk("R10", "oe after write", sdioOe, 0);
    frame(1, 15'h0011, 8'h00, 24, q);
    chk("R6", "readback 0011", q, 8'h07);
    // R8: aborted write four bits short
    frame(0, 15'h0005, 8'h00, 20, q);
    chk("R8", "aborted write", opMode, 2);
    frame(1, 15'h0005, 8'h00, 24, q);
    chk("R8", "readback after abort", q, 8'h02);
    frame(1, 15'h0123, 8'h00, 24, q);
    chk("R7", "unmapped read", q, 8'h00);
    // R9: soft reset
    frame(0, 15'h0005, 8'h81, 24, q);
    chk("R9", "reset pulse count", rstSeen, rstExp);
    chk("R9", "opMode default", opMode, 0);
    chk("R9", "lvdsSel strapped", lvdsSel, 1);
    chk("R9", "dataFmt strapped", dataFmt, 0);
    chk("R9", "dcsEn default", dcsEn, 1);
    chk("R9", "still serial", serialMode, 1);
    frame(1, 15'h0005, 8'h00, 24, q);
    chk("R9", "reset bit reads 0", q, 8'h00);
    frame(1, 15'h0011, 8'h00, 24, q);
    chk("R9", "0011 after reset", q, 8'h08);
    chk("R9", "single pulse", rstSeen, 1);
    hold();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule